// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block turns an asynchronous serial line into parallel words. The line idles high, and a frame opens with a low start bit. Seven or eight data bits follow, least significant bit first. An even or odd parity bit may come next, and the frame closes with one or two high stop bits. The receiver synchronizes the line and waits for a falling edge. It then times every bit from that edge, so that each bit is sampled at its middle. This leaves close to half a bit of margin for rate mismatch across a word.

The bit period in clock cycles and the frame format are run-time inputs. The block captures them at the start edge, so software or a neighbouring block may change them while a frame is in flight without corrupting that frame. Each finished word appears on a registered output with a one-cycle valid strobe, together with separate parity and framing error flags. The word and the flags then hold until the next word arrives.

Top module: `serial_frame_rx`

## Requirements
- R1: After reset, `valid_o`, `parity_err_o` and `frame_err_o` are 0 and `data_o` is 0x00.
- R2: With `eight_bits_i`=1, the data bits are assembled least significant bit first into `data_o[7:0]`. `valid_o` pulses high for exactly one cycle after the final stop bit is sampled, and it does so exactly once per frame.
- R3: With `eight_bits_i`=0, seven data bits are received into `data_o[6:0]` and `data_o[7]` is 0.
- R4: `parity_mode_i` is encoded as follows: 2'b01 selects even parity and 2'b10 selects odd parity. In even mode, `parity_err_o` is 1 when the data bits plus the parity bit hold an odd number of ones. In odd mode, it is 1 when they hold an even number of ones.
- R5: `parity_mode_i` 2'b00 (none) and 2'b11 (reserved, treated as none) consume no parity bit, and they always report `parity_err_o`=0.
- R6: A stop bit sampled low sets `frame_err_o` for that word. The word is still delivered with `valid_o`.
- R7: With `two_stop_i`=1, two stop bits are sampled, and either one being low sets `frame_err_o`. With `two_stop_i`=0, only one stop bit is sampled.
- R8: A low pulse that has ended by the middle of the start bit is discarded. No word is produced, and the receiver is ready for the next edge.
- R9: `div_i`, `eight_bits_i`, `parity_mode_i` and `two_stop_i` are captured at the start edge. Changing them during a frame has no effect on that frame.
- R10: `div_i` gives the bit period in clock cycles, and any value from 2*SYNC_STAGES+2 upward is valid. Each bit is sampled within one clock of its middle, with the synchronizer delay included in the timing.
- R11: `data_o`, `parity_err_o` and `frame_err_o` change only with a `valid_o` pulse, and they hold their values between words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_i | input | 1 | Asynchronous serial line, idle high |
| div_i | input | DIV_W | Bit period in clock cycles |
| eight_bits_i | input | 1 | 1: eight data bits, 0: seven |
| parity_mode_i | input | 2 | 00 none, 01 even, 10 odd, 11 none |
| two_stop_i | input | 1 | 1: two stop bits, 0: one |
| data_o | output | 8 | Received word |
| valid_o | output | 1 | One-cycle strobe for a new word |
| parity_err_o | output | 1 | Parity mismatch on the current word |
| frame_err_o | output | 1 | Low stop bit on the current word |

## Verification
A wrong bit counter or format register shows up at the first word after the fault. The data comes out shifted, or an extra or missing bit throws the parity and stop samples off by one position, and both flags turn wrong on that same strobe. A timer fault moves the sample point. With a short divisor, this corrupts the last bits of the very next frame, while a lost state either drops the strobe or produces a second one, which the per-frame word count exposes within two bit periods.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

   localparam int unsigned WORD_W = 8;
   localparam int unsigned BCNT_W = $clog2(WORD_W);

   typedef enum logic [1:0] {
      PAR_NONE = 2'd0,
      PAR_EVEN = 2'd1,
      PAR_ODD  = 2'd2,
      PAR_RSVD = 2'd3
   } parity_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PARITY,
      ST_STOP
   } rx_state_e;

   typedef struct packed {
      logic    eight;
      parity_e par;
      logic    two_stop;
   } frame_fmt_t;

endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("rx_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[0] <= RESET_VAL;
            else        chain_q[0] <= d_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[g] <= RESET_VAL;
            else        chain_q[g] <= chain_q[g-1];
         end
      end
   end

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/rx_bit_timer.sv
module rx_bit_timer #(
   parameter int unsigned DIV_W = 16,
   parameter int unsigned LAT   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic             half_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             tick_o
);

   if (DIV_W < 4) begin : g_bad_width
      $error("rx_bit_timer: DIV_W must be at least 4");
   end

   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] lim;

   // First window ends mid start bit, shortened by the synchronizer delay.
   assign lim    = half_i ? ((div_i >> 1) - DIV_W'(LAT)) : (div_i - DIV_W'(1));
   assign tick_o = run_i && (cnt_q == lim);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cnt_q <= '0;
      else if (clear_i || tick_o || !run_i)  cnt_q <= '0;
      else                                   cnt_q <= cnt_q + DIV_W'(1);
   end

   AST_CNT_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cnt_q <= lim)) else $error("timer count beyond window"); // R10

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
   import serial_rx_pkg::*;
#(
   parameter int unsigned DIV_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_i,
   input  logic [DIV_W-1:0]  div_i,
   input  frame_fmt_t        fmt_i,
   input  logic              tick_i,
   output logic              clear_o,
   output logic              run_o,
   output logic              half_o,
   output logic [DIV_W-1:0]  div_o,
   output logic [WORD_W-1:0] data_o,
   output logic              valid_o,
   output logic              par_err_o,
   output logic              frm_err_o
);

   rx_state_e           state_q;
   frame_fmt_t          fmt_q;
   logic [DIV_W-1:0]    div_q;
   logic [WORD_W-1:0]   shift_q;
   logic [BCNT_W-1:0]   bit_cnt_q;
   logic                stop_cnt_q;
   logic                prev_q;
   logic                par_acc_q;
   logic                par_bad_q;
   logic                frm_bad_q;

   logic                start_edge;
   logic                has_par;
   logic                want_odd;
   logic [BCNT_W-1:0]   last_bit;
   logic                last_stop;

   assign start_edge = (state_q == ST_IDLE) && prev_q && !line_i;
   assign has_par    = (fmt_q.par == PAR_EVEN) || (fmt_q.par == PAR_ODD);
   assign want_odd   = (fmt_q.par == PAR_ODD);
   assign last_bit   = fmt_q.eight ? BCNT_W'(WORD_W - 1) : BCNT_W'(WORD_W - 2);
   assign last_stop  = !fmt_q.two_stop || stop_cnt_q;

   assign clear_o = start_edge;
   assign run_o   = (state_q != ST_IDLE);
   assign half_o  = (state_q == ST_START);
   assign div_o   = div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= line_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= ST_IDLE;
         fmt_q      <= '0;
         div_q      <= '0;
         shift_q    <= '0;
         bit_cnt_q  <= '0;
         stop_cnt_q <= 1'b0;
         par_acc_q  <= 1'b0;
         par_bad_q  <= 1'b0;
         frm_bad_q  <= 1'b0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_edge) begin
                  state_q    <= ST_START;
                  fmt_q      <= fmt_i;
                  div_q      <= div_i;
                  bit_cnt_q  <= '0;
                  stop_cnt_q <= 1'b0;
                  par_acc_q  <= 1'b0;
                  par_bad_q  <= 1'b0;
                  frm_bad_q  <= 1'b0;
               end
            end
            ST_START: begin
               if (tick_i) state_q <= line_i ? ST_IDLE : ST_DATA;
            end
            ST_DATA: begin
               if (tick_i) begin
                  shift_q   <= {line_i, shift_q[WORD_W-1:1]};
                  par_acc_q <= par_acc_q ^ line_i;
                  if (bit_cnt_q == last_bit) begin
                     bit_cnt_q <= '0;
                     state_q   <= has_par ? ST_PARITY : ST_STOP;
                  end else begin
                     bit_cnt_q <= bit_cnt_q + BCNT_W'(1);
                  end
               end
            end
            ST_PARITY: begin
               if (tick_i) begin
                  par_bad_q <= ((par_acc_q ^ line_i) != want_odd);
                  state_q   <= ST_STOP;
               end
            end
            ST_STOP: begin
               if (tick_i) begin
                  frm_bad_q  <= frm_bad_q | !line_i;
                  stop_cnt_q <= 1'b1;
                  if (last_stop) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // Output register: loads only when the final stop bit is sampled.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o    <= '0;
         valid_o   <= 1'b0;
         par_err_o <= 1'b0;
         frm_err_o <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (state_q == ST_STOP && tick_i && last_stop) begin
            valid_o   <= 1'b1;
            data_o    <= fmt_q.eight ? shift_q : {1'b0, shift_q[WORD_W-1:1]};
            par_err_o <= par_bad_q;
            frm_err_o <= frm_bad_q | !line_i;
         end
      end
   end

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |=> !valid_o) else $error("valid held longer than one cycle"); // R2

   AST_VALID_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o |-> (state_q == ST_IDLE)) else $error("valid outside idle"); // R2

   AST_SEVEN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !fmt_q.eight) |-> !data_o[WORD_W-1]) else $error("top bit set in 7-bit mode"); // R3

   AST_NO_PAR_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_o && !has_par) |-> !par_err_o) else $error("parity error without parity"); // R5

   AST_GLITCH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_START && tick_i && line_i) |=> (state_q == ST_IDLE && !valid_o))
      else $error("glitch not discarded"); // R8

   AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> ($stable(fmt_q) && $stable(div_q)))
      else $error("format changed inside frame"); // R9

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_o |-> ($stable(data_o) && $stable(par_err_o) && $stable(frm_err_o)))
      else $error("outputs moved without strobe"); // R11

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
   import serial_rx_pkg::*;
#(
   parameter int unsigned DIV_W       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_i,
   input  logic [DIV_W-1:0]  div_i,
   input  logic              eight_bits_i,
   input  logic [1:0]        parity_mode_i,
   input  logic              two_stop_i,
   output logic [WORD_W-1:0] data_o,
   output logic              valid_o,
   output logic              parity_err_o,
   output logic              frame_err_o
);

   localparam int unsigned MIN_DIV = 2 * SYNC_STAGES + 2;

   if (DIV_W < 4 || (2 ** DIV_W) <= MIN_DIV) begin : g_bad_div
      $error("serial_frame_rx: DIV_W cannot hold the minimum divisor");
   end

   logic             line_sync;
   logic             tick;
   logic             clear;
   logic             run;
   logic             half;
   logic [DIV_W-1:0] div_lat;
   frame_fmt_t       fmt_in;

   assign fmt_in.eight    = eight_bits_i;
   assign fmt_in.par      = parity_e'(parity_mode_i);
   assign fmt_in.two_stop = two_stop_i;

   rx_line_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (rx_i),
      .q_o   (line_sync)
   );

   rx_bit_timer #(
      .DIV_W (DIV_W),
      .LAT   (SYNC_STAGES)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (clear),
      .run_i   (run),
      .half_i  (half),
      .div_i   (div_lat),
      .tick_o  (tick)
   );

   rx_frame_ctrl #(
      .DIV_W (DIV_W)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_sync),
      .div_i     (div_i),
      .fmt_i     (fmt_in),
      .tick_i    (tick),
      .clear_o   (clear),
      .run_o     (run),
      .half_o    (half),
      .div_o     (div_lat),
      .data_o    (data_o),
      .valid_o   (valid_o),
      .par_err_o (parity_err_o),
      .frm_err_o (frame_err_o)
   );

endmodule

// File: tb/tb_serial_frame_rx.sv
module tb_serial_frame_rx;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx = 1'b1;
   logic [15:0] div_r = 16'd16;
   logic        bits8_r = 1'b1;
   logic [1:0]  pmode_r = 2'd0;
   logic        stop2_r = 1'b0;
   logic [7:0]  data;
   logic        valid;
   logic        perr;
   logic        ferr;

   int n_checks = 0;
   int n_fail   = 0;
   int got_cnt  = 0;
   logic [7:0] got_data = '0;
   logic       got_perr = 1'b0;
   logic       got_ferr = 1'b0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   serial_frame_rx #(.DIV_W(16), .SYNC_STAGES(2)) dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .rx_i          (rx),
      .div_i         (div_r),
      .eight_bits_i  (bits8_r),
      .parity_mode_i (pmode_r),
      .two_stop_i    (stop2_r),
      .data_o        (data),
      .valid_o       (valid),
      .parity_err_o  (perr),
      .frame_err_o   (ferr)
   );

   always @(negedge clk) begin
      if (rst_n && valid) begin
         got_cnt  = got_cnt + 1;
         got_data = data;
         got_perr = perr;
         got_ferr = ferr;
      end
   end

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic drive(input logic v, input int cycles);
      #1 rx = v;
      repeat (cycles) @(posedge clk);
   endtask

   task automatic send_frame(input logic [7:0] d, input bit flip_par,
                             input bit s1, input bit s2, input bit mangle);
      int   n   = int'(div_r);
      int   nb  = bits8_r ? 8 : 7;
      logic [1:0] pm = pmode_r;
      bit   two = stop2_r;
      logic p;
      drive(1'b0, n);
      if (mangle) begin
         bits8_r = ~bits8_r;
         pmode_r = 2'd2;
         stop2_r = ~stop2_r;
         div_r   = div_r + 16'd9;
      end
      for (int i = 0; i < nb; i++) drive(d[i], n);
      if (pm == 2'd1 || pm == 2'd2) begin
         p = (nb == 8) ? ^d : ^d[6:0];
         if (pm == 2'd2) p = ~p;
         if (flip_par)   p = ~p;
         drive(p, n);
      end
      drive(s1, n);
      if (two) drive(s2, n);
      drive(1'b1, 2 * n);
   endtask

   task automatic frame_case(input string req, input logic [7:0] d, input bit flip_par,
                             input bit s1, input bit s2, input bit mangle,
                             input bit exp_perr, input bit exp_ferr);
      int c0 = got_cnt;
      logic [7:0] exp_d = bits8_r ? d : {1'b0, d[6:0]};
      send_frame(d, flip_par, s1, s2, mangle);
      @(negedge clk);
      check(req, "word count", got_cnt - c0, 1);
      check(req, "data", {24'd0, got_data}, {24'd0, exp_d});
      check(req, "parity flag", {31'd0, got_perr}, {31'd0, exp_perr});
      check(req, "frame flag", {31'd0, got_ferr}, {31'd0, exp_ferr});
   endtask

   task automatic set_cfg(input int dv, input bit b8, input logic [1:0] pm, input bit s2);
      div_r = 16'(dv); bits8_r = b8; pmode_r = pm; stop2_r = s2;
   endtask

   task automatic t_reset;
      @(negedge clk);
      check("R1", "data after reset", {24'd0, data}, 32'd0);
      check("R1", "valid after reset", {31'd0, valid}, 32'd0);
      check("R1", "parity flag after reset", {31'd0, perr}, 32'd0);
      check("R1", "frame flag after reset", {31'd0, ferr}, 32'd0);
   endtask

   task automatic t_basic;
      set_cfg(16, 1, 2'd0, 0);
      frame_case("R2", 8'hA5, 0, 1, 1, 0, 0, 0);
      frame_case("R2", 8'h3C, 0, 1, 1, 0, 0, 0);
      frame_case("R5", 8'h01, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_seven;
      set_cfg(16, 0, 2'd0, 0);
      frame_case("R3", 8'hFF, 0, 1, 1, 0, 0, 0);
      frame_case("R3", 8'h41, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_parity;
      set_cfg(16, 1, 2'd1, 0);
      frame_case("R4 even ok", 8'h61, 0, 1, 1, 0, 0, 0);
      frame_case("R4 even bad", 8'h61, 1, 1, 1, 0, 1, 0);
      set_cfg(16, 1, 2'd2, 0);
      frame_case("R4 odd ok", 8'h7A, 0, 1, 1, 0, 0, 0);
      frame_case("R4 odd bad", 8'h7A, 1, 1, 1, 0, 1, 0);
      set_cfg(16, 0, 2'd1, 0);
      frame_case("R4 even 7bit bad", 8'h39, 1, 1, 1, 0, 1, 0);
      set_cfg(16, 1, 2'd3, 0);
      frame_case("R5 reserved", 8'h5A, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_framing;
      set_cfg(16, 1, 2'd0, 0);
      frame_case("R6", 8'h62, 0, 0, 1, 0, 0, 1);
      frame_case("R6 recover", 8'h63, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_two_stop;
      set_cfg(16, 1, 2'd1, 1);
      frame_case("R7 second low", 8'h30, 0, 1, 0, 0, 0, 1);
      frame_case("R7 first low", 8'h31, 0, 0, 1, 0, 0, 1);
      frame_case("R7 both high", 8'h39, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_glitch;
      int c0;
      set_cfg(16, 1, 2'd0, 0);
      c0 = got_cnt;
      drive(1'b0, 3);
      drive(1'b1, 16 * 12);
      @(negedge clk);
      check("R8", "words after glitch", got_cnt - c0, 0);
      frame_case("R8 after glitch", 8'h42, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_latched;
      set_cfg(16, 1, 2'd0, 0);
      frame_case("R9", 8'hC3, 0, 1, 1, 1, 0, 0);
      set_cfg(16, 1, 2'd0, 0);
      frame_case("R9 next", 8'h5A, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_divisor;
      set_cfg(6, 1, 2'd2, 0);
      frame_case("R10 min div", 8'h96, 0, 1, 1, 0, 0, 0);
      set_cfg(37, 0, 2'd1, 1);
      frame_case("R10 long div", 8'h64, 0, 1, 1, 0, 0, 0);
   endtask

   task automatic t_hold;
      logic [7:0] d0;
      set_cfg(16, 1, 2'd1, 0);
      frame_case("R11 setup", 8'h7E, 1, 0, 1, 0, 1, 1);
      d0 = data;
      repeat (200) @(posedge clk);
      @(negedge clk);
      check("R11", "data held", {24'd0, data}, 32'h7E);
      check("R11", "parity flag held", {31'd0, perr}, 32'd1);
      check("R11", "frame flag held", {31'd0, ferr}, 32'd1);
      check("R11", "valid idle", {31'd0, valid}, 32'd0);
      check("R11", "data unchanged", {24'd0, data}, {24'd0, d0});
   endtask

   initial begin
      repeat (5) @(posedge clk);
      t_reset;
      #1 rst_n = 1'b1;
      repeat (20) @(posedge clk);
      t_reset;
      t_basic;
      t_seven;
      t_parity;
      t_framing;
      t_two_stop;
      t_glitch;
      t_latched;
      t_divisor;
      t_hold;
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule